// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital control loop that sits beside a 12-bit successive-approximation converter. Once armed, it waits for a start request, either written by software or raised by a hardware event, and then steps through a sixteen-entry table of conversion descriptors. Each descriptor names an analog input channel and picks one of two sample-time limits. A 10-bit counter holds the sample phase open for that limit. The controller then sends a single-cycle start pulse to the converter, waits for its done pulse and forwards the returned code as a one-cycle write strobe tagged with the descriptor index.

Five operating modes cover one-shot and repeating use, over a single descriptor or over a run of descriptors from a first to a last index. A run wraps modulo sixteen, so a last index below the first index is allowed. One-shot modes park the controller after the run. It then ignores requests until it is re-armed by dropping and raising the enable. Repeating modes go back to waiting for the next request. A request that arrives while a conversion is under way is dropped and leaves a sticky overflow flag set. The descriptor table and the mode inputs are written while the enable is low.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After the synchronous reset, `busy_o`, `sample_o`, `adc_start_o`, `res_we_o` and `ovf_o` are all low.
- R2: While enabled and idle, a request starts a run at descriptor `start_idx_i`. A request is a one-cycle `sw_trig_i`, or a one-cycle `evt_trig_i` in any mode except the ad-hoc one.
- R3: For each conversion, `sample_o` is high for exactly N+1 consecutive cycles. N is `samp_cmp0_i` when the descriptor's select bit (`tbl_tsel_i` when it was written) is 0, and `samp_cmp1_i` when it is 1. This holds for N=0 and for N=1023.
- R4: `sample_o` falls with a one-cycle `adc_start_o`. While that pulse is high, `adc_chan_o` carries the channel stored in the descriptor being converted.
- R5: Every `adc_done_i` in the converting phase produces a one-cycle `res_we_o` in the next cycle. It carries the descriptor index on `res_idx_o` and the `adc_data_i` value on `res_data_o`.
- R6: Mode code 0 (single) and mode code 1 (repeat single) convert only descriptor `start_idx_i`, once per request.
- R7: Mode code 2 (sequence) and mode code 3 (repeat sequence) convert descriptors `start_idx_i`, `start_idx_i`+1, and so on, modulo 16, up to and including `end_idx_i`.
- R8: After a run in mode 0 or mode 2 completes, further requests start nothing and set no flag until `en_i` goes low and then high again. Taking `en_i` low in the middle of a run aborts it with no result strobe.
- R9: After a run in mode 1 or mode 3, the controller is idle again, and each new request repeats the same run.
- R10: In mode code 4 (ad-hoc), `evt_trig_i` is ignored. Each `sw_trig_i` converts descriptor `start_idx_i` once, and the controller stays ready for the next request.
- R11: A request that arrives during a sampling or converting phase is dropped and does not lengthen the run. It sets `ovf_o`, which stays high until reset, even across re-arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Arms the controller; low forces idle |
| mode_i | input | 3 | Operating mode code (0..4) |
| start_idx_i | input | 4 | First descriptor of a run |
| end_idx_i | input | 4 | Last descriptor of a run |
| sw_trig_i | input | 1 | Software start request |
| evt_trig_i | input | 1 | Event start request |
| samp_cmp0_i | input | 10 | Sample-time limit 0 |
| samp_cmp1_i | input | 10 | Sample-time limit 1 |
| tbl_we_i | input | 1 | Descriptor write enable |
| tbl_addr_i | input | 4 | Descriptor write index |
| tbl_chan_i | input | 4 | Channel field of written descriptor |
| tbl_tsel_i | input | 1 | Sample-limit select of written descriptor |
| sample_o | output | 1 | Sample phase active |
| adc_start_o | output | 1 | One-cycle converter start pulse |
| adc_chan_o | output | 4 | Channel of current descriptor |
| adc_done_i | input | 1 | Converter done pulse |
| adc_data_i | input | 12 | Converter code, valid with done |
| res_we_o | output | 1 | Result write strobe |
| res_idx_o | output | 4 | Result slot index |
| res_data_o | output | 12 | Result code |
| busy_o | output | 1 | Sampling or converting |
| ovf_o | output | 1 | Sticky dropped-request flag |

## Verification
The bench looks for off-by-one errors in the sample window at limit 0 and at limit 1023. A design that gets this wrong shows a sample pulse one cycle short or long, or one that never ends. It runs a run that wraps from index 14 through 0 to 1, which catches a controller that stops at 15 or never finds its last index. It sends requests to a parked one-shot controller, a busy one and an ad-hoc one fed by events. A wrong design would start a second run, append extra conversions, lose the sticky flag or convert in response to an event. Random runs across all modes and converter latencies compare each strobed index and code against a model of the descriptor table.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    MODE_SINGLE     = 3'd0,
    MODE_RPT_SINGLE = 3'd1,
    MODE_SEQ        = 3'd2,
    MODE_RPT_SEQ    = 3'd3,
    MODE_ADHOC      = 3'd4
  } conv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2,
    ST_HALT   = 2'd3
  } seq_state_e;

  // modes that return to waiting for a request after the run
  function automatic logic mode_repeats(input logic [2:0] m);
    return (m == MODE_RPT_SINGLE) || (m == MODE_RPT_SEQ) || (m == MODE_ADHOC);
  endfunction

  // modes that walk a range of descriptors
  function automatic logic mode_walks(input logic [2:0] m);
    return (m == MODE_SEQ) || (m == MODE_RPT_SEQ);
  endfunction

endpackage

// File: rtl/adc_seq_tbl.sv
module adc_seq_tbl #(
  parameter int N_ENT = 16,
  parameter int CH_W  = 4,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [CH_W-1:0]  wchan,
  input  logic             wtsel,
  input  logic [IDX_W-1:0] raddr,
  output logic [CH_W-1:0]  rchan,
  output logic             rtsel
);
  localparam int ENT_W = CH_W + 1;

  logic [ENT_W-1:0] mem [N_ENT];
  logic [ENT_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wtsel, wchan};
    rd_q <= mem[raddr];
  end

  assign rchan = rd_q[CH_W-1:0];
  assign rtsel = rd_q[CH_W];
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sel,
  input  logic [CNT_W-1:0] cmp0,
  input  logic [CNT_W-1:0] cmp1,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = sel ? cmp1 : cmp0;
  assign hit   = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || hit) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sw,
  input  logic evt,
  input  logic adhoc,
  input  logic armed,
  input  logic busy,
  output logic go,
  output logic ovf
);
  logic req;

  assign req = sw || (evt && !adhoc);
  assign go  = en && armed && req;

  always_ff @(posedge clk) begin
    if (rst)                    ovf <= 1'b0;
    else if (en && busy && req) ovf <= 1'b1;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int CH_W  = 4,
  parameter int RES_W = 12,
  parameter int CNT_W = 10,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [2:0]       mode_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic [IDX_W-1:0] end_idx_i,
  input  logic             sw_trig_i,
  input  logic             evt_trig_i,
  input  logic [CNT_W-1:0] samp_cmp0_i,
  input  logic [CNT_W-1:0] samp_cmp1_i,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_addr_i,
  input  logic [CH_W-1:0]  tbl_chan_i,
  input  logic             tbl_tsel_i,
  output logic             sample_o,
  output logic             adc_start_o,
  output logic [CH_W-1:0]  adc_chan_o,
  input  logic             adc_done_i,
  input  logic [RES_W-1:0] adc_data_i,
  output logic             res_we_o,
  output logic [IDX_W-1:0] res_idx_o,
  output logic [RES_W-1:0] res_data_o,
  output logic             busy_o,
  output logic             ovf_o
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N_ENT - 1);

  seq_state_e       st;
  logic [IDX_W-1:0] idx, idx_nxt, idx_inc;
  logic             go, hit, last, ent_tsel;
  logic [CH_W-1:0]  ent_chan;

  assign busy_o   = (st == ST_SAMPLE) || (st == ST_CONV);
  assign sample_o = (st == ST_SAMPLE);
  assign idx_inc  = (idx == LAST_SLOT) ? '0 : idx + 1'b1;
  assign last     = !mode_walks(mode_i) || (idx == end_idx_i);

  adc_seq_trig u_trig (
    .clk   (clk),
    .rst   (rst),
    .en    (en_i),
    .sw    (sw_trig_i),
    .evt   (evt_trig_i),
    .adhoc (mode_i == MODE_ADHOC),
    .armed (st == ST_IDLE),
    .busy  (busy_o),
    .go    (go),
    .ovf   (ovf_o)
  );

  adc_seq_tbl #(.N_ENT(N_ENT), .CH_W(CH_W), .IDX_W(IDX_W)) u_tbl (
    .clk   (clk),
    .we    (tbl_we_i),
    .waddr (tbl_addr_i),
    .wchan (tbl_chan_i),
    .wtsel (tbl_tsel_i),
    .raddr (idx_nxt),
    .rchan (ent_chan),
    .rtsel (ent_tsel)
  );

  adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (st == ST_SAMPLE),
    .sel  (ent_tsel),
    .cmp0 (samp_cmp0_i),
    .cmp1 (samp_cmp1_i),
    .hit  (hit)
  );

  assign adc_chan_o = ent_chan;

  // next descriptor index; also the table read address, so the entry
  // is ready in the same cycle the index register takes this value
  always_comb begin
    idx_nxt = idx;
    if (en_i) begin
      unique case (st)
        ST_IDLE: if (go) idx_nxt = start_idx_i;
        ST_CONV: if (adc_done_i && !last) idx_nxt = idx_inc;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      idx         <= '0;
      adc_start_o <= 1'b0;
      res_we_o    <= 1'b0;
      res_idx_o   <= '0;
      res_data_o  <= '0;
    end else begin
      idx         <= idx_nxt;
      adc_start_o <= 1'b0;
      res_we_o    <= 1'b0;
      if (!en_i) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_IDLE: if (go) st <= ST_SAMPLE;
          ST_SAMPLE: begin
            if (hit) begin
              st          <= ST_CONV;
              adc_start_o <= 1'b1;
            end
          end
          ST_CONV: begin
            if (adc_done_i) begin
              res_we_o   <= 1'b1;
              res_idx_o  <= idx;
              res_data_o <= adc_data_i;
              if (!last)                   st <= ST_SAMPLE;
              else if (mode_repeats(mode_i)) st <= ST_IDLE;
              else                         st <= ST_HALT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic sample_o,
  input logic adc_start_o,
  input logic adc_done_i,
  input logic res_we_o,
  input logic ovf_o
);
  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start_o |=> !adc_start_o);

  // R4
  sample_end_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sample_o) && $past(en_i)) |-> adc_start_o);

  // R5
  result_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_we_o |=> !res_we_o);

  // R5
  result_cause_chk: assert property (@(posedge clk) disable iff (rst)
    res_we_o |-> $past(adc_done_i));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sample_o && adc_start_o));
endmodule

bind adc_seq_ctrl adc_seq_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .en_i        (en_i),
  .sample_o    (sample_o),
  .adc_start_o (adc_start_o),
  .adc_done_i  (adc_done_i),
  .res_we_o    (res_we_o),
  .ovf_o       (ovf_o)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [3:0]  start_idx_i = 4'd0, end_idx_i = 4'd0;
  logic        sw_trig_i = 1'b0, evt_trig_i = 1'b0;
  logic [9:0]  samp_cmp0_i = 10'd3, samp_cmp1_i = 10'd7;
  logic        tbl_we_i = 1'b0;
  logic [3:0]  tbl_addr_i = 4'd0, tbl_chan_i = 4'd0;
  logic        tbl_tsel_i = 1'b0;
  logic        sample_o, adc_start_o, res_we_o, busy_o, ovf_o;
  logic [3:0]  adc_chan_o, res_idx_o;
  logic        adc_done_i = 1'b0;
  logic [11:0] adc_data_i = 12'd0, res_data_o;

  always #4 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (.*);

  int nchk = 0, nbad = 0;
  bit finished = 1'b0;
  logic [3:0] tb_ch [16];
  logic       tb_ts [16];

  // converter model
  int lat_len = 3, lat_cnt = 0;
  logic [3:0] lat_chan = '0;
  logic [7:0] conv_no = '0;
  always @(negedge clk) begin
    adc_done_i = 1'b0;
    if (rst) begin
      lat_cnt = 0; conv_no = '0;
    end else begin
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          adc_done_i = 1'b1;
          adc_data_i = {lat_chan, conv_no};
          conv_no++;
        end
      end
      if (adc_start_o) begin lat_cnt = lat_len; lat_chan = adc_chan_o; end
    end
  end

  // monitors
  int ncap = 0, nslen = 0, run = 0, dbl = 0;
  int cidx [64]; int cdat [64]; int slen [64];
  logic prev_start = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (sample_o) run++;
      else if (run > 0) begin
        if (nslen < 64) slen[nslen] = run;
        nslen++; run = 0;
      end
      if (res_we_o) begin
        if (ncap < 64) begin cidx[ncap] = res_idx_o; cdat[ncap] = res_data_o; end
        ncap++;
      end
      if (adc_start_o && prev_start) dbl++;
      prev_start = adc_start_o;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_ent(input int i, input logic [3:0] ch, input logic ts);
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_addr_i = 4'(i); tbl_chan_i = ch; tbl_tsel_i = ts;
    tb_ch[i] = ch; tb_ts[i] = ts;
    @(negedge clk);
    tbl_we_i = 1'b0;
  endtask

  task automatic rearm();
    @(negedge clk); en_i = 1'b0;
    @(negedge clk); en_i = 1'b1;
  endtask

  task automatic trig(input bit evt);
    @(negedge clk);
    if (evt) evt_trig_i = 1'b1; else sw_trig_i = 1'b1;
    @(negedge clk);
    evt_trig_i = 1'b0; sw_trig_i = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (lat_len + 2) @(negedge clk);
  endtask

  function automatic int exp_count(input int m, input int s, input int e);
    if (m == 2 || m == 3) return ((e - s + 16) % 16) + 1;
    return 1;
  endfunction

  // one request, then compare every strobe against the table model
  task automatic job(input string tag, input int m, input int s, input int e,
                     input bit evt, input int expn);
    logic [7:0] base;
    @(negedge clk);
    mode_i = 3'(m); start_idx_i = 4'(s); end_idx_i = 4'(e);
    ncap = 0; nslen = 0;
    base = conv_no;
    trig(evt);
    wait_idle();
    chk({tag, " count"}, ncap, expn);
    for (int i = 0; i < ncap && i < 64; i++) begin
      int id;
      logic [7:0] seqn;
      id = (s + i) % 16;
      seqn = base + 8'(i);
      chk({tag, " idx"}, cidx[i], id);
      chk({tag, " data/chan R4 R5"}, cdat[i], int'({tb_ch[id], seqn}));
      chk({tag, " sample len R3"}, slen[i],
          int'(tb_ts[id] ? samp_cmp1_i : samp_cmp0_i) + 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 sample", int'(sample_o), 0);
    chk("R1 start", int'(adc_start_o), 0);
    chk("R1 res_we", int'(res_we_o), 0);
    chk("R1 ovf", int'(ovf_o), 0);

    for (int i = 0; i < 16; i++) wr_ent(i, 4'($urandom_range(15)), 1'($urandom_range(1)));
    @(negedge clk); en_i = 1'b1;

    // R2 R6 single by software request
    job("R6 single", 0, 5, 5, 1'b0, 1);
    // R8 parked after one-shot
    job("R8 parked single", 0, 5, 5, 1'b0, 0);
    chk("R8 no flag when parked", int'(ovf_o), 0);

    // R2 R9 repeat single by event
    rearm();
    job("R9 rpt single a", 1, 2, 9, 1'b1, 1);
    job("R9 rpt single b", 1, 2, 9, 1'b1, 1);

    // R7 wrapping sequence, then parked
    rearm();
    job("R7 wrap seq", 2, 14, 1, 1'b1, 4);
    job("R8 parked seq", 2, 14, 1, 1'b1, 0);

    // R9 repeat sequence
    rearm();
    job("R9 rpt seq a", 3, 3, 6, 1'b0, 4);
    job("R9 rpt seq b", 3, 3, 6, 1'b1, 4);

    // R10 ad-hoc
    job("R10 adhoc evt", 4, 7, 7, 1'b1, 0);
    job("R10 adhoc sw a", 4, 7, 7, 1'b0, 1);
    job("R10 adhoc sw b", 4, 11, 11, 1'b0, 1);
    chk("R10 no flag from evt", int'(ovf_o), 0);

    // R3 limits 0 and 1023
    @(negedge clk); en_i = 1'b0;
    samp_cmp0_i = 10'd0; samp_cmp1_i = 10'd1023;
    wr_ent(9, 4'd6, 1'b0);
    wr_ent(10, 4'd12, 1'b1);
    @(negedge clk); en_i = 1'b1;
    job("R3 extreme limits", 2, 9, 10, 1'b0, 2);

    // R8 abort mid-sample
    rearm();
    samp_cmp0_i = 10'd9; samp_cmp1_i = 10'd9;
    @(negedge clk);
    mode_i = 3'd2; start_idx_i = 4'd0; end_idx_i = 4'd3;
    ncap = 0;
    trig(1'b0);
    @(negedge clk); en_i = 1'b0;
    @(negedge clk);
    chk("R8 abort busy", int'(busy_o), 0);
    repeat (20) @(negedge clk);
    chk("R8 abort no strobe", ncap, 0);
    @(negedge clk); en_i = 1'b1;

    // R11 request while busy
    samp_cmp0_i = 10'd3; samp_cmp1_i = 10'd5;
    @(negedge clk);
    mode_i = 3'd2; start_idx_i = 4'd0; end_idx_i = 4'd15;
    ncap = 0;
    trig(1'b0);
    repeat (5) @(negedge clk);
    chk("R11 busy before", int'(busy_o), 1);
    trig(1'b1);
    wait_idle();
    chk("R11 dropped request", ncap, 16);
    chk("R11 flag set", int'(ovf_o), 1);
    rearm();
    chk("R11 flag sticky", int'(ovf_o), 1);

    // random runs over all modes
    for (int k = 0; k < 24; k++) begin
      int m, s, e;
      @(negedge clk); en_i = 1'b0;
      samp_cmp0_i = 10'($urandom_range(15));
      samp_cmp1_i = 10'($urandom_range(15));
      lat_len = $urandom_range(5, 1);
      for (int i = 0; i < 16; i++) wr_ent(i, 4'($urandom_range(15)), 1'($urandom_range(1)));
      @(negedge clk); en_i = 1'b1;
      m = $urandom_range(4);
      s = $urandom_range(15);
      e = $urandom_range(15);
      job($sformatf("R2 R6 R7 R10 random mode %0d", m), m, s, e,
          (m == 4) ? 1'b0 : 1'($urandom_range(1)), exp_count(m, s, e));
    end

    chk("R4 single-cycle start", dbl, 0);
    chk("R11 flag still set", int'(ovf_o), 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule